// File: doc/BRIEF.md
# Disk Controller Status and Command Timeout Unit

This unit assembles the status a disk controller reports to its host. It watches the signals of the currently selected drive (index pulse, ready, write fault, head-at-outer-track) and the seek-complete lines of every attached drive. From these it builds an 8-bit main status byte and a 4-bit auxiliary nibble. It also tracks whether a data transfer command is in progress and abandons any transfer that is still running after a fixed number of disk revolutions.

The command sequencer in front of it strobes in each command with a one-cycle pulse, says whether the command moves data and in which direction, and later pulses a transfer-done input together with the result of the CRC check. The watchdog counts synchronised index pulses rather than clock cycles, so its limit follows rotation speed. Completion, timeout and seek flags are sticky: any command, including one that does nothing, clears them.

The raw index and seek-complete inputs are asynchronous to the controller clock. Each passes through a two-flop synchroniser before its rising edge is detected.

Top module: `dkst_status`

## Requirements
- R1: Main status bit positions: 7 idle, 6 index level, 5 drive-not-ready (1 when `drv_ready_i` is 0), 4 no-fault (1 when `drv_fault_i` is 0), 3 timed out, 2 all seeks complete, 1 transfer finished, 0 not-at-track-zero (1 when `drv_trk0_i` is 0). Bits 5, 4 and 0 follow their inputs in the same cycle.
- R2: A command strobe with `cmd_xfer_i`=1 raises `busy_o` and clears status bit 7 on the next clock. A strobe with `cmd_xfer_i`=0 leaves `busy_o` at 0 and bit 7 at 1. After reset, `busy_o` is 0 and bit 7 is 1.
- R3: Status bit 6 starts at 0 after reset and inverts once for every index pulse.
- R4: If a transfer is still busy when the TIMEOUT_REVS-th index pulse since its strobe is detected, status bit 3 sets, `busy_o` drops, bit 7 returns to 1 on that same clock, and `abort_o` is high for exactly one cycle.
- R5: A `xfer_done_i` pulse while busy ends the transfer and sets status bit 1. If it arrives on the same clock as the final watchdog pulse, completion wins and no timeout is recorded.
- R6: Every command strobe, including a no-op, clears status bits 3 and 1 and auxiliary bits 1 and 0. The clear takes priority over any set on that clock.
- R7: Status bit 2 is 1 only when all NUM_DRIVES synchronised seek-complete lines are 1.
- R8: Auxiliary bit 0 sets when status bit 2 rises from 0 to 1, and stays set when bit 2 falls again.
- R9: Auxiliary bit 1 is cleared by each strobe. It sets when a read transfer (`cmd_read_i`=1 at the strobe) ends through `xfer_done_i` with `crc_nonzero_i`=1. A write, or a transfer ended by timeout, never sets it.
- R10: Auxiliary bits 3:2 carry the revision code 3-REVISION: revision 0 gives 11 and revision 3 gives 00.
- R11: Index pulses are counted only while busy, and the count restarts at each strobe. Pulses seen while idle do not shorten the next command's window.
- R12: A `xfer_done_i` pulse while not busy is ignored and leaves status bit 1 and auxiliary bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_raw_i | input | 1 | Index pulse from the selected drive, asynchronous |
| drv_ready_i | input | 1 | Selected drive ready |
| drv_fault_i | input | 1 | Selected drive write fault |
| drv_trk0_i | input | 1 | Selected drive heads at track zero |
| seek_raw_i | input | NUM_DRIVES | Seek-complete line of each drive, asynchronous |
| cmd_strobe_i | input | 1 | One-cycle pulse that accepts a new command |
| cmd_xfer_i | input | 1 | Command moves data (qualifies the strobe) |
| cmd_read_i | input | 1 | Transfer is disk-to-controller (qualifies the strobe) |
| xfer_done_i | input | 1 | One-cycle pulse at the end of a transfer |
| crc_nonzero_i | input | 1 | CRC remainder nonzero, sampled with `xfer_done_i` |
| status_o | output | 8 | Main status byte |
| aux_o | output | 4 | Auxiliary status nibble |
| busy_o | output | 1 | Transfer in progress |
| abort_o | output | 1 | One-cycle pulse when the watchdog ends a transfer |

## Verification
On every cycle the assertions check the following clock-to-clock rules. A strobe clears the sticky flags and retry bit, and a transfer strobe makes the unit busy. Completion while busy ends the transfer and records it. An abort coincides with the timeout flag and the idle bit and lasts one cycle. A rise of the all-seeks bit sets the seek flag. Only the bench scenarios can show the counting behaviour: that exactly the TIMEOUT_REVS-th index pulse trips the watchdog and that idle pulses never count. They also show the index toggling, the read/write distinction for retry, the revision code, and the completion-versus-timeout outcome of randomly sized transfers.

// File: rtl/dkst_pkg.sv
package dkst_pkg;
   // main status byte bit positions (host software decodes these)
   localparam int ST_IDLE   = 7;
   localparam int ST_IDX    = 6;
   localparam int ST_NRDY   = 5;
   localparam int ST_NFLT   = 4;
   localparam int ST_TMO    = 3;
   localparam int ST_SEEK   = 2;
   localparam int ST_XDONE  = 1;
   localparam int ST_NTRK0  = 0;
   // auxiliary nibble bit positions
   localparam int AX_SEEKED = 0;
   localparam int AX_RETRY  = 1;

   typedef struct packed {
      logic busy;
      logic rd_dir;
      logic timed_out;
      logic xfer_done;
      logic seeked;
      logic retry;
      logic idx_lvl;
      logic abort;
   } dkst_state_t;

   function automatic logic [1:0] rev_code(input int rev);
      return 2'(3 - rev);
   endfunction
endpackage

// File: rtl/dkst_sync.sv
module dkst_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dkst_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dkst_rise.sv
module dkst_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/dkst_watchdog.sv
module dkst_watchdog #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic run_i,
   input  logic tick_i,
   output logic expire_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("dkst_watchdog: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart_i)        cnt_q <= '0;
      else if (run_i && tick_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/dkst_status.sv
module dkst_status
   import dkst_pkg::*;
#(
   parameter int NUM_DRIVES   = 4,
   parameter int TIMEOUT_REVS = 8,
   parameter int REVISION     = 0,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  idx_raw_i,
   input  logic                  drv_ready_i,
   input  logic                  drv_fault_i,
   input  logic                  drv_trk0_i,
   input  logic [NUM_DRIVES-1:0] seek_raw_i,
   input  logic                  cmd_strobe_i,
   input  logic                  cmd_xfer_i,
   input  logic                  cmd_read_i,
   input  logic                  xfer_done_i,
   input  logic                  crc_nonzero_i,
   output logic [7:0]            status_o,
   output logic [3:0]            aux_o,
   output logic                  busy_o,
   output logic                  abort_o
);
   localparam int SW = NUM_DRIVES + 1;
   localparam logic [1:0] REV_BITS = rev_code(REVISION);

   if (NUM_DRIVES < 1 || NUM_DRIVES > 8) begin : g_bad_drives
      $error("dkst_status: NUM_DRIVES must be 1..8");
   end
   if (REVISION < 0 || REVISION > 3) begin : g_bad_rev
      $error("dkst_status: REVISION must be 0..3");
   end

   // synchronise index and seek lines together
   logic [SW-1:0]         sync_q;
   logic                  idx_s;
   logic [NUM_DRIVES-1:0] seek_s;

   dkst_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({idx_raw_i, seek_raw_i}),
      .q_o   (sync_q)
   );
   assign idx_s  = sync_q[SW-1];
   assign seek_s = sync_q[NUM_DRIVES-1:0];

   logic all_seek;
   if (NUM_DRIVES == 1) begin : g_one_drive
      assign all_seek = seek_s[0];
   end else begin : g_many_drives
      assign all_seek = &seek_s;
   end

   logic idx_rise, seek_rise;
   dkst_rise u_idx_rise  (.clk(clk), .rst_n(rst_n), .lvl_i(idx_s),    .rise_o(idx_rise));
   dkst_rise u_seek_rise (.clk(clk), .rst_n(rst_n), .lvl_i(all_seek), .rise_o(seek_rise));

   dkst_state_t st_q, st_d;
   logic        wd_expire;

   dkst_watchdog #(.LIMIT(TIMEOUT_REVS)) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (cmd_strobe_i),
      .run_i     (st_q.busy),
      .tick_i    (idx_rise),
      .expire_o  (wd_expire)
   );

   always_comb begin
      st_d       = st_q;
      st_d.abort = 1'b0;
      if (idx_rise) st_d.idx_lvl = ~st_q.idx_lvl;
      if (cmd_strobe_i) begin
         // a new command wipes every sticky result
         st_d.busy      = cmd_xfer_i;
         st_d.rd_dir    = cmd_read_i;
         st_d.timed_out = 1'b0;
         st_d.xfer_done = 1'b0;
         st_d.seeked    = 1'b0;
         st_d.retry     = 1'b0;
      end else begin
         if (st_q.busy && xfer_done_i) begin
            st_d.busy      = 1'b0;
            st_d.xfer_done = 1'b1;
            if (st_q.rd_dir && crc_nonzero_i) st_d.retry = 1'b1;
         end else if (wd_expire) begin
            st_d.busy      = 1'b0;
            st_d.timed_out = 1'b1;
            st_d.abort     = 1'b1;
         end
         if (seek_rise) st_d.seeked = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   always_comb begin
      status_o           = '0;
      status_o[ST_IDLE]  = ~st_q.busy;
      status_o[ST_IDX]   = st_q.idx_lvl;
      status_o[ST_NRDY]  = ~drv_ready_i;
      status_o[ST_NFLT]  = ~drv_fault_i;
      status_o[ST_TMO]   = st_q.timed_out;
      status_o[ST_SEEK]  = all_seek;
      status_o[ST_XDONE] = st_q.xfer_done;
      status_o[ST_NTRK0] = ~drv_trk0_i;
   end

   assign aux_o   = {REV_BITS, st_q.retry, st_q.seeked};
   assign busy_o  = st_q.busy;
   assign abort_o = st_q.abort;
endmodule

// File: rtl/dkst_status_chk.sv
module dkst_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_strobe_i,
   input logic       cmd_xfer_i,
   input logic       xfer_done_i,
   input logic [7:0] status_o,
   input logic [3:0] aux_o,
   input logic       busy_o,
   input logic       abort_o
);
   // R2
   p_xfer_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe_i && cmd_xfer_i |=> busy_o && !status_o[7]);

   // R4
   p_abort_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> status_o[3] && status_o[7] && !busy_o);

   p_abort_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   // R5
   p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && xfer_done_i && !cmd_strobe_i |=> !busy_o && status_o[1] && !abort_o);

   // R6
   p_cmd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe_i |=> !status_o[3] && !status_o[1] && !aux_o[0]);

   // R8
   p_seek_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[2]) && !cmd_strobe_i |=> aux_o[0]);

   // R9
   p_retry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe_i |=> !aux_o[1]);

   // R12
   p_idle_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && xfer_done_i && !cmd_strobe_i |=> $stable(status_o[1]) && $stable(aux_o[1]));
endmodule

bind dkst_status dkst_status_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_strobe_i (cmd_strobe_i),
   .cmd_xfer_i   (cmd_xfer_i),
   .xfer_done_i  (xfer_done_i),
   .status_o     (status_o),
   .aux_o        (aux_o),
   .busy_o       (busy_o),
   .abort_o      (abort_o)
);

// File: tb/dkst_status_bench.sv
module dkst_status_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ND   = 4;
   localparam int REVS = 8;
   localparam int REV  = 0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idx_raw = 1'b0, rdy = 1'b0, flt = 1'b0, trk0 = 1'b0;
   logic [ND-1:0] seek = '0;
   logic          strobe = 1'b0, xfer = 1'b0, rd = 1'b0, done = 1'b0, crc = 1'b0;
   logic [7:0]    status;
   logic [3:0]    aux;
   logic          busy, abort;

   int n_tests = 0, n_fail = 0, abort_cnt = 0;
   bit finished = 1'b0;

   // expected model state
   logic e_busy = 0, e_idx = 0, e_tmo = 0, e_done = 0, e_seeked = 0, e_retry = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dkst_status #(.NUM_DRIVES(ND), .TIMEOUT_REVS(REVS), .REVISION(REV)) u_dkst_status (
      .clk(clk), .rst_n(rst_n), .idx_raw_i(idx_raw), .drv_ready_i(rdy),
      .drv_fault_i(flt), .drv_trk0_i(trk0), .seek_raw_i(seek),
      .cmd_strobe_i(strobe), .cmd_xfer_i(xfer), .cmd_read_i(rd),
      .xfer_done_i(done), .crc_nonzero_i(crc),
      .status_o(status), .aux_o(aux), .busy_o(busy), .abort_o(abort)
   );

   always @(negedge clk) if (rst_n && abort) abort_cnt++;

   function automatic logic [7:0] exp_status();
      return {~e_busy, e_idx, ~rdy, ~flt, e_tmo, &seek, e_done, ~trk0};
   endfunction

   function automatic logic [3:0] exp_aux();
      return {2'(3 - REV), e_retry, e_seeked};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " status"}, 32'(status), 32'(exp_status()));
      chk({tag, " aux"},    32'(aux),    32'(exp_aux()));
      chk({tag, " busy"},   32'(busy),   32'(e_busy));
   endtask

   task automatic idx_pulse();
      @(negedge clk) idx_raw = 1'b1;
      repeat (3) @(negedge clk);
      idx_raw = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic command(input logic x, input logic r);
      @(negedge clk) begin strobe = 1'b1; xfer = x; rd = r; end
      @(negedge clk) begin strobe = 1'b0; xfer = 1'b0; rd = 1'b0; end
      @(negedge clk);
   endtask

   task automatic finish_xfer(input logic c);
      @(negedge clk) begin done = 1'b1; crc = c; end
      @(negedge clk) begin done = 1'b0; crc = 1'b0; end
      @(negedge clk);
   endtask

   task automatic set_seek(input logic [ND-1:0] v);
      @(negedge clk) seek = v;
      repeat (6) @(negedge clk);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired got=hung exp=done");
         summary();
      end
   end

   initial begin
      int seed_v;
      int last_abort;
      seed_v = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R2 R3 R10: reset state
      chk_all("R1 R2 R3 R10 reset");
      chk("R10 revision code", 32'(aux[3:2]), 32'd3);

      // R1: level bits follow the drive lines
      for (int i = 0; i < 8; i++) begin
         @(negedge clk) begin rdy = 1'($urandom); flt = 1'($urandom); trk0 = 1'($urandom); end
         #1 chk_all("R1 drive lines");
      end
      @(negedge clk) begin rdy = 1'b1; flt = 1'b0; end

      // R3: index level toggles per pulse
      for (int i = 0; i < 3; i++) begin
         idx_pulse(); e_idx = ~e_idx;
         chk_all("R3 index toggle");
      end

      // R7 R8: seek-complete AND and sticky flag
      set_seek(4'b0111); chk_all("R7 partial seek");
      set_seek(4'b1111); e_seeked = 1'b1; chk_all("R7 R8 all seek");
      set_seek(4'b1011); chk_all("R8 seek flag sticky");

      // R6 R2: no-op clears flags, no busy
      command(1'b0, 1'b0); e_seeked = 1'b0; chk_all("R2 R6 no-op");

      // R2 R5 R9: read transfer with CRC error
      command(1'b1, 1'b1); e_busy = 1'b1; chk_all("R2 read start");
      repeat (3) begin idx_pulse(); e_idx = ~e_idx; end
      finish_xfer(1'b1); e_busy = 0; e_done = 1; e_retry = 1;
      chk_all("R5 R9 read crc done");

      // R6 R9: write transfer with CRC set does not raise retry
      command(1'b1, 1'b0); e_busy = 1; e_done = 0; e_retry = 0;
      chk_all("R6 R9 write start clears");
      finish_xfer(1'b1); e_busy = 0; e_done = 1;
      chk_all("R9 write crc no retry");

      // R12: done while idle ignored
      command(1'b0, 1'b0); e_done = 0;
      finish_xfer(1'b1); chk_all("R12 idle done ignored");

      // R11 R4: idle pulses not counted, exact limit
      repeat (5) begin idx_pulse(); e_idx = ~e_idx; end
      command(1'b1, 1'b1); e_busy = 1;
      last_abort = abort_cnt;
      repeat (REVS - 1) begin idx_pulse(); e_idx = ~e_idx; end
      chk_all("R11 one short of limit");
      idx_pulse(); e_idx = ~e_idx; e_busy = 0; e_tmo = 1;
      chk_all("R4 timeout");
      chk("R4 abort pulses", 32'(abort_cnt - last_abort), 32'd1);
      finish_xfer(1'b1); chk_all("R12 R9 done after timeout");
      command(1'b0, 1'b0); e_tmo = 0; chk_all("R6 no-op clears timeout");

      // random transfers
      for (int k = 0; k < 20; k++) begin
         logic r, c;
         int np;
         r = 1'($urandom); c = 1'($urandom); np = int'($urandom % 11);
         last_abort = abort_cnt;
         command(1'b1, r); e_busy = 1; e_done = 0; e_tmo = 0; e_retry = 0; e_seeked = 0;
         chk_all("R2 R6 random start");
         for (int p = 0; p < np; p++) begin idx_pulse(); e_idx = ~e_idx; end
         if (np >= REVS) begin e_busy = 0; e_tmo = 1; end
         finish_xfer(c);
         if (np < REVS) begin e_busy = 0; e_done = 1; e_retry = r & c; end
         chk_all("R4 R5 R9 random end");
         chk("R4 random abort count", 32'(abort_cnt - last_abort), (np >= REVS) ? 32'd1 : 32'd0);
      end

      finished = 1'b1;
      summary();
   end
endmodule